// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides, for one memory access at a time, whether a 32-bit address may be read, written or fetched from. It keeps two banks of sixteen region descriptors, one for the hypervisor level and one shared by the kernel and user levels. Each descriptor is a base word and a limit word. Regions are aligned to 64 bytes and include both their first and their last byte. A matching region supplies the access rights, an execute-never flag, a shareability code and an index into a packed 64-bit memory attribute table.

Requests arrive on a valid/ready stream and carry the address, the level, a privileged flag and the access kind. Each accepted request produces one registered response on a second valid/ready stream, one clock later. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value. Descriptors, per-level control bits and the attribute table are written through a plain write port. A write takes effect for requests accepted from the next clock edge onward.

Top module: `prot_region_unit`

## Requirements
- R1: A region covers every address from its base word with bits [5:0] cleared up to and including its limit word with bits [5:0] set.
- R2: A region whose limit word bit 0 is clear never matches.
- R3: Requests with `req_hyp`=1 search the hypervisor bank and use hypervisor control. All other requests use the kernel/user bank and control.
- R4: If control bit 0 (enable) of the selected level is clear, the response grants read, write and execute, reports cause 0, and returns hit 0, attribute 0, shareability 0 and region 0.
- R5: Base word bits [2:1] hold the permission code. The code sets read/write rights as follows:
  - 00: privileged read/write, no unprivileged access.
  - 01: read/write for both.
  - 10: privileged read only, no unprivileged access.
  - 11: read only for both.
- R6: Execute is granted only when read or write is granted and execute-never is clear. Execute-never is forced on in two further cases:
  - Base word bit 0 is set, or control bit 2 is set and write is granted.
  - At the kernel/user level only: control bit 3 is set and the code is 01.
- R7: On a single match, `rsp_attr` is byte k of the attribute table (bits 8k+7..8k), where k is limit word bits [3:1]. `rsp_sh` is limit word bits [4:3]. If k is above 4, the response has cause 3, no rights and hit 0.
- R8: When no enabled region matches, the response has cause 1 and no rights. The exception is a request with `req_priv`=1 while control bit 1 (background enable) is set.
- R9: In the background case, read and write are granted and hit is 0. Execute is granted only when the address is at most 0x7FFF_FFFF. For hypervisor requests, execute is also removed when control bit 2 is set.
- R10: `req_acc` 00 asks for read, 01 for write, and any value with bit 1 set for fetch. If the requested right is not granted on an otherwise good result, the cause is 2 and the rights are still reported.
- R11: When two or more enabled regions match, the response has cause 3, hit 0, region 0 and no rights.
- R12: A response appears exactly one cycle after acceptance and holds under back-pressure. `rsp_fault` is high exactly when `rsp_cause` is non-zero.
- R13: Configuration write map on `cfg_addr` (7 bits):
  - Bit 6 clear selects a descriptor. Bit 5 picks the bank (1 = hypervisor), bit 4 picks the word (1 = limit, 0 = base), and bits [3:0] give the region index.
  - Bit 6 set selects a register by bits [1:0]: 0 = kernel control, 1 = hypervisor control, 2 = attribute table bits [31:0], 3 = attribute table bits [63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Access address |
| req_hyp | input | 1 | Request at hypervisor level |
| req_priv | input | 1 | Privileged request |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 1x fetch |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_r | output | 1 | Read granted |
| rsp_w | output | 1 | Write granted |
| rsp_x | output | 1 | Execute granted |
| rsp_attr | output | 8 | Memory attribute byte |
| rsp_sh | output | 2 | Shareability code |
| rsp_region | output | 4 | Matched region index |
| rsp_hit | output | 1 | A single descriptor matched |
| rsp_fault | output | 1 | Access fault |
| rsp_cause | output | 2 | 0 none, 1 miss, 2 denied, 3 conflict |

## Verification
A corrupted descriptor or control bit shows in the very next response that touches the affected address range. It appears as wrong rights, a moved region edge, a wrong attribute byte or a changed cause. A fault in the match logic, such as an off-by-one at a 64-byte edge or a bank mix-up, shows only when an address lands on a boundary or when both levels hold different descriptors. For that reason the stimulus aims addresses at region edges and exercises both banks. A broken stall path shows within one cycle of `rsp_ready` going low, as a changed field or a dropped `rsp_valid`.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_MISS     = 2'd1,
    CAUSE_DENY     = 2'd2,
    CAUSE_CONFLICT = 2'd3
  } cause_e;

  localparam int CTL_W    = 4;
  localparam int CTL_EN   = 0;
  localparam int CTL_BG   = 1;
  localparam int CTL_WXN  = 2;
  localparam int CTL_UWXN = 3;

  localparam int GRAN_BITS = 6;
  localparam int ATTR_MAX  = 4;

  // returns {read, write} for a permission code
  function automatic logic [1:0] ap_rights(input logic [1:0] ap, input logic priv);
    logic rd, wr;
    if (priv) begin
      rd = 1'b1;
      wr = ~ap[1];
    end else begin
      rd = ap[0];
      wr = ap[0] & ~ap[1];
    end
    return {rd, wr};
  endfunction
endpackage

// File: rtl/prot_region_match.sv
module prot_region_match
  import prot_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [31:0]            addr,
  input  logic [NREG-1:0][31:0]  base_w,
  input  logic [NREG-1:0][31:0]  lim_w,
  output logic [$clog2(NREG)-1:0] idx,
  output logic                   none,
  output logic                   multi
);
  localparam int IW = $clog2(NREG);

  logic [NREG-1:0] hit_v;
  logic [IW:0]     cnt;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    logic [31:0] lo, hi;
    assign lo = {base_w[g][31:GRAN_BITS], {GRAN_BITS{1'b0}}};
    assign hi = {lim_w[g][31:GRAN_BITS], {GRAN_BITS{1'b1}}};
    assign hit_v[g] = lim_w[g][0] && (addr >= lo) && (addr <= hi);
  end

  always_comb begin
    idx = '0;
    cnt = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_v[i]) idx = i[IW-1:0];
      cnt = cnt + {{IW{1'b0}}, hit_v[i]};
    end
  end

  assign none  = (hit_v == '0);
  assign multi = (cnt > (IW+1)'(1));
endmodule

// File: rtl/prot_perm_eval.sv
module prot_perm_eval
  import prot_pkg::*;
(
  input  logic [31:0]      base_w,
  input  logic [31:0]      lim_w,
  input  logic [CTL_W-1:0] ctrl,
  input  logic             hyp,
  input  logic             priv,
  input  logic             addr_msb,
  input  logic             none,
  input  logic             multi,
  input  logic [1:0]       acc,
  input  logic [63:0]      attr_tab,
  output logic             rd,
  output logic             wr,
  output logic             ex,
  output logic [7:0]       attr,
  output logic [1:0]       sh,
  output logic             hit,
  output cause_e           cause
);
  logic [2:0] aidx;
  logic [1:0] ap;
  logic       xn;
  logic       granted;

  assign aidx = lim_w[3:1];
  assign ap   = base_w[2:1];

  always_comb begin
    rd = 1'b0; wr = 1'b0; ex = 1'b0;
    attr = '0; sh = '0; hit = 1'b0; xn = 1'b0;
    cause = CAUSE_NONE;
    if (!ctrl[CTL_EN]) begin
      rd = 1'b1; wr = 1'b1; ex = 1'b1;
    end else if (multi) begin
      cause = CAUSE_CONFLICT;
    end else if (none) begin
      if (priv && ctrl[CTL_BG]) begin
        rd = 1'b1;
        wr = 1'b1;
        ex = !addr_msb && !(hyp && ctrl[CTL_WXN]);
      end else begin
        cause = CAUSE_MISS;
      end
    end else if (aidx > 3'(ATTR_MAX)) begin
      cause = CAUSE_CONFLICT;
    end else begin
      {rd, wr} = ap_rights(ap, priv);
      xn = base_w[0] | (ctrl[CTL_WXN] & wr) | (!hyp & ctrl[CTL_UWXN] & (ap == 2'b01));
      ex = (rd | wr) & !xn;
      attr = attr_tab[8*aidx +: 8];
      sh = lim_w[4:3];
      hit = 1'b1;
    end
    granted = acc[1] ? ex : (acc[0] ? wr : rd);
    if (cause == CAUSE_NONE && !granted) cause = CAUSE_DENY;
  end
endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit
  import prot_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NREG)+2:0]  cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [31:0]              req_addr,
  input  logic                     req_hyp,
  input  logic                     req_priv,
  input  logic [1:0]               req_acc,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic                     rsp_r,
  output logic                     rsp_w,
  output logic                     rsp_x,
  output logic [7:0]               rsp_attr,
  output logic [1:0]               rsp_sh,
  output logic [$clog2(NREG)-1:0]  rsp_region,
  output logic                     rsp_hit,
  output logic                     rsp_fault,
  output logic [1:0]               rsp_cause
);
  localparam int IW  = $clog2(NREG);
  localparam int CAW = IW + 3;

  logic [1:0][NREG-1:0][31:0] base_q, lim_q;
  logic [1:0][CTL_W-1:0]      ctl_q;
  logic [63:0]                attr_q;

  // configuration storage, bank 1 = hypervisor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      ctl_q  <= '0;
      attr_q <= '0;
    end else if (cfg_we) begin
      if (!cfg_addr[CAW-1]) begin
        if (cfg_addr[IW]) lim_q[cfg_addr[IW+1]][cfg_addr[IW-1:0]] <= cfg_wdata;
        else              base_q[cfg_addr[IW+1]][cfg_addr[IW-1:0]] <= cfg_wdata;
      end else begin
        case (cfg_addr[1:0])
          2'd0:    ctl_q[0] <= cfg_wdata[CTL_W-1:0];
          2'd1:    ctl_q[1] <= cfg_wdata[CTL_W-1:0];
          2'd2:    attr_q[31:0] <= cfg_wdata;
          default: attr_q[63:32] <= cfg_wdata;
        endcase
      end
    end
  end

  logic [IW-1:0] m_idx;
  logic          m_none, m_multi;

  prot_region_match #(.NREG(NREG)) u_match (
    .addr   (req_addr),
    .base_w (base_q[req_hyp]),
    .lim_w  (lim_q[req_hyp]),
    .idx    (m_idx),
    .none   (m_none),
    .multi  (m_multi)
  );

  logic       e_r, e_w, e_x, e_hit;
  logic [7:0] e_attr;
  logic [1:0] e_sh;
  cause_e     e_cause;

  prot_perm_eval u_eval (
    .base_w   (base_q[req_hyp][m_idx]),
    .lim_w    (lim_q[req_hyp][m_idx]),
    .ctrl     (ctl_q[req_hyp]),
    .hyp      (req_hyp),
    .priv     (req_priv),
    .addr_msb (req_addr[31]),
    .none     (m_none),
    .multi    (m_multi),
    .acc      (req_acc),
    .attr_tab (attr_q),
    .rd       (e_r),
    .wr       (e_w),
    .ex       (e_x),
    .attr     (e_attr),
    .sh       (e_sh),
    .hit      (e_hit),
    .cause    (e_cause)
  );

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_r      <= 1'b0;
      rsp_w      <= 1'b0;
      rsp_x      <= 1'b0;
      rsp_attr   <= '0;
      rsp_sh     <= '0;
      rsp_region <= '0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_cause  <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_r      <= e_r;
      rsp_w      <= e_w;
      rsp_x      <= e_x;
      rsp_attr   <= e_attr;
      rsp_sh     <= e_sh;
      rsp_region <= e_hit ? m_idx : '0;
      rsp_hit    <= e_hit;
      rsp_fault  <= (e_cause != CAUSE_NONE);
      rsp_cause  <= e_cause;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_region_unit_chk.sv
module prot_region_unit_chk #(
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic                    rsp_r,
  input logic                    rsp_w,
  input logic                    rsp_x,
  input logic [7:0]              rsp_attr,
  input logic [1:0]              rsp_sh,
  input logic [$clog2(NREG)-1:0] rsp_region,
  input logic                    rsp_hit,
  input logic                    rsp_fault,
  input logic [1:0]              rsp_cause
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R12

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_r, rsp_w, rsp_x, rsp_attr,
      rsp_sh, rsp_region, rsp_hit, rsp_fault, rsp_cause})); // R12

  AST_EXEC_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_x |-> rsp_r || rsp_w); // R6

  AST_MISS_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cause == 2'd1 |-> !rsp_r && !rsp_w && !rsp_x && !rsp_hit && rsp_fault); // R8

  AST_CONFLICT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cause == 2'd3 |-> !rsp_hit && rsp_region == '0 && !rsp_r && !rsp_w && !rsp_x); // R11

  AST_ATTR_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_attr == 8'h00 && rsp_sh == 2'b00); // R7
endmodule

bind prot_region_unit prot_region_unit_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/prot_region_unit_bench.sv
module prot_region_unit_bench;
  localparam int NREG = 16;

  typedef struct packed {
    logic       r, w, x;
    logic [7:0] attr;
    logic [1:0] sh;
    logic [3:0] region;
    logic       hit;
    logic [1:0] cause;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        req_hyp = 1'b0, req_priv = 1'b0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic        rsp_r, rsp_w, rsp_x, rsp_hit, rsp_fault;
  logic [7:0]  rsp_attr;
  logic [1:0]  rsp_sh, rsp_cause;
  logic [3:0]  rsp_region;

  int checks = 0, errors = 0;

  logic [31:0] mb [2][NREG];
  logic [31:0] ml [2][NREG];
  logic [3:0]  mc [2];
  logic [63:0] mat;

  always #5 clk = ~clk;

  prot_region_unit #(.NREG(NREG)) u_prot_region_unit (.*);

  function automatic exp_t model(input logic [31:0] a, input logic hy, input logic pv,
                                 input logic [1:0] ac);
    exp_t e = '0;
    int cnt = 0, idx = 0;
    logic [3:0] c = mc[hy];
    logic [2:0] k;
    logic [1:0] ap;
    logic xn, g;
    for (int n = NREG - 1; n >= 0; n--) begin
      if (ml[hy][n][0] && a >= {mb[hy][n][31:6], 6'h00} && a <= {ml[hy][n][31:6], 6'h3f}) begin
        cnt++;
        idx = n;
      end
    end
    if (!c[0]) begin
      e.r = 1; e.w = 1; e.x = 1;
      return e;
    end
    if (cnt > 1) begin e.cause = 3; return e; end
    if (cnt == 0) begin
      if (!(pv && c[1])) begin e.cause = 1; return e; end
      e.r = 1; e.w = 1;
      e.x = (a <= 32'h7FFF_FFFF) && !(hy && c[2]);
    end else begin
      k = ml[hy][idx][3:1];
      if (k > 4) begin e.cause = 3; return e; end
      ap = mb[hy][idx][2:1];
      case (ap)
        2'b00: begin e.r = pv; e.w = pv; end
        2'b01: begin e.r = 1;  e.w = 1;  end
        2'b10: begin e.r = pv; e.w = 0;  end
        default: begin e.r = 1; e.w = 0; end
      endcase
      xn = mb[hy][idx][0] || (c[2] && e.w) || (!hy && c[3] && ap == 2'b01);
      e.x = (e.r || e.w) && !xn;
      e.attr = mat[8*k +: 8];
      e.sh = ml[hy][idx][4:3];
      e.region = idx[3:0];
      e.hit = 1;
    end
    g = ac[1] ? e.x : (ac[0] ? e.w : e.r);
    if (!g) e.cause = 2;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] ad, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = ad; cfg_wdata = d;
    if (!ad[6]) begin
      if (ad[4]) ml[ad[5]][ad[3:0]] = d; else mb[ad[5]][ad[3:0]] = d;
    end else case (ad[1:0])
      2'd0: mc[0] = d[3:0];
      2'd1: mc[1] = d[3:0];
      2'd2: mat[31:0] = d;
      default: mat[63:32] = d;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(input logic [31:0] a, input logic hy, input logic pv,
                      input logic [1:0] ac, input string tag);
    exp_t e = model(a, hy, pv, ac);
    exp_t got;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_hyp = hy; req_priv = pv; req_acc = ac;
    @(negedge clk);
    req_valid = 0;
    got = {rsp_r, rsp_w, rsp_x, rsp_attr, rsp_sh, rsp_region, rsp_hit, rsp_cause};
    check(rsp_valid === 1'b1, {tag, " R12 valid"}, 64'(rsp_valid), 64'd1);
    check(got === e, tag, 64'(got), 64'(e));
    check(rsp_fault === (e.cause != 0), {tag, " R12 fault"}, 64'(rsp_fault), 64'(e.cause != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_t held;
    void'($urandom(32'd20240611));
    for (int b = 0; b < 2; b++) begin
      mc[b] = '0;
      for (int n = 0; n < NREG; n++) begin mb[b][n] = '0; ml[b][n] = '0; end
    end
    mat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid === 0 && req_ready === 1, "R12 reset state", 64'({rsp_valid, req_ready}), 64'd1);

    look(32'h1234_5678, 0, 0, 2'b10, "R4 bypass kernel");
    look(32'hF000_0000, 1, 0, 2'b01, "R4 bypass hyp");

    wr(7'h40, 32'h1);                       // R13 kernel control enable
    wr(7'h42, 32'hDDCC_BBAA);
    wr(7'h43, 32'h0000_00EE);
    wr(7'h03, 32'h1000_0042);               // region 3 base, code 01
    wr(7'h13, 32'h1000_0085);               // limit, enable, attr index 2
    look(32'h1000_0040, 0, 0, 2'b00, "R1 base edge");
    check(rsp_attr === 8'hCC, "R7 attr byte 2", 64'(rsp_attr), 64'hCC);
    check(rsp_region === 4'd3, "R13 region index", 64'(rsp_region), 64'd3);
    look(32'h1000_003F, 0, 0, 2'b00, "R1 below base");
    look(32'h1000_00BF, 0, 1, 2'b01, "R1 limit edge");
    look(32'h1000_00C0, 0, 1, 2'b00, "R8 above limit no bg");
    look(32'h1000_0080, 1, 1, 2'b00, "R3 hyp bank empty");

    wr(7'h43, 32'h0000_0000);
    wr(7'h13, 32'h1000_008D);               // attr index 6
    look(32'h1000_0050, 0, 1, 2'b00, "R7 illegal attr index");
    wr(7'h13, 32'h1000_009B);               // index 5 with sh bits
    look(32'h1000_0050, 0, 1, 2'b00, "R7 attr index 5");
    wr(7'h13, 32'h1000_0099);               // index 4, sh 11
    look(32'h1000_0050, 0, 1, 2'b00, "R7 attr index 4 sh");
    wr(7'h13, 32'h1000_0084);
    look(32'h1000_0050, 0, 1, 2'b00, "R2 region disabled");
    wr(7'h13, 32'h1000_0081);

    for (int ap = 0; ap < 4; ap++) begin
      wr(7'h03, 32'h1000_0040 | 32'(ap << 1));
      for (int pv = 0; pv < 2; pv++) begin
        look(32'h1000_0060, 0, pv[0], 2'b01, "R5 code write");
        look(32'h1000_0060, 0, pv[0], 2'b10, "R10 code fetch");
      end
    end
    wr(7'h03, 32'h1000_0043);
    look(32'h1000_0060, 0, 1, 2'b10, "R6 xn bit");
    wr(7'h03, 32'h1000_0042);
    wr(7'h40, 32'h5);
    look(32'h1000_0060, 0, 1, 2'b10, "R6 wxn");
    wr(7'h40, 32'h9);
    look(32'h1000_0060, 0, 1, 2'b10, "R6 uwxn kernel");

    wr(7'h40, 32'h3);
    look(32'h8000_0000, 0, 1, 2'b10, "R9 bg upper no exec");
    look(32'h7FFF_FFFF, 0, 1, 2'b10, "R9 bg lower exec");
    look(32'h7FFF_FFFF, 0, 0, 2'b00, "R8 bg unpriv miss");
    wr(7'h41, 32'h7);
    wr(7'h39, 32'h1000_0009);               // hyp region 9 uwxn must not apply
    wr(7'h29, 32'h1000_0002);
    look(32'h7000_0000, 1, 1, 2'b10, "R9 hyp bg wxn");
    wr(7'h41, 32'h3);
    look(32'h7000_0000, 1, 1, 2'b10, "R9 hyp bg exec");
    look(32'h1000_0010, 1, 0, 2'b00, "R3 hyp bank region");

    wr(7'h05, 32'h1000_0080);
    wr(7'h15, 32'h1000_0101);
    look(32'h1000_0090, 0, 1, 2'b00, "R11 overlap");
    look(32'h1000_00C0, 0, 1, 2'b00, "R1 second region only");

    // back-pressure
    rsp_ready = 0;
    look(32'h1000_00C0, 0, 1, 2'b00, "R12 stall capture");
    held = {rsp_r, rsp_w, rsp_x, rsp_attr, rsp_sh, rsp_region, rsp_hit, rsp_cause};
    check(req_ready === 0, "R12 ready low in stall", 64'(req_ready), 64'd0);
    @(negedge clk);
    check(rsp_valid === 1 && {rsp_r, rsp_w, rsp_x, rsp_attr, rsp_sh, rsp_region, rsp_hit, rsp_cause} === held,
          "R12 hold under stall", 64'(rsp_valid), 64'd1);
    rsp_ready = 1;
    @(negedge clk);
    check(rsp_valid === 0, "R12 drain", 64'(rsp_valid), 64'd0);

    // random
    for (int it = 0; it < 600; it++) begin
      int sel = $urandom % 8;
      if (sel < 2) begin
        logic [31:0] bs = 32'h2000_0000 + ($urandom % 4096);
        logic [3:0] n = 4'($urandom);
        logic hb = 1'($urandom);
        wr({1'b0, hb, 1'b0, n}, bs | ($urandom & 32'h7));
        wr({1'b0, hb, 1'b1, n}, bs + ($urandom % 1024) | ($urandom & 32'h1F) | 32'(($urandom % 4) != 0));
      end else if (sel == 2) begin
        wr({5'b10000, 1'b0, 1'($urandom)}, 32'($urandom % 16));
      end else if (sel == 3) begin
        wr({5'b10000, 1'b1, 1'($urandom)}, $urandom);
      end else begin
        logic [31:0] a = ($urandom % 8 == 0) ? $urandom : 32'h2000_0000 + ($urandom % 5200);
        look(a, 1'($urandom), 1'($urandom), 2'($urandom), "R1 R5 R6 R7 R8 R9 R10 R11 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule